// File: doc/BRIEF.md
# MSI Snoopy Coherence Controller

This block keeps coherence state for one write-back cache that shares a snooping bus with other caches. A small direct-mapped array holds a tag and a three-state coherence code per line. Local processor reads and writes that the current state permits are answered in the same cycle. A read miss, a write miss or a write to a read-only line becomes a bus transaction. The controller requests the bus, waits for grant and completion, and only then commits the new line state and raises ready.

While it does this, the controller watches the commands that other caches put on the bus. A matching dirty line is flushed, so its data can be supplied, and is then downgraded or invalidated. A matching clean line is dropped on an exclusive request. A dirty line that a miss is about to replace is flushed as a write-back. The data array, memory timing and bus arbitration sit outside the block.

Top module: `msi_coh_ctrl`

## Requirements
- R1: State codes are Invalid=00, Shared=01, Modified=10, and every line is Invalid after reset. Bus and snoop command codes are 00 none, 01 read, 10 read-exclusive and 11 upgrade. The first read of any address after reset issues bus command 01 with that address.
- R2: On a read miss, the controller raises bus_req_o with command 01 in the cycle after the request. After grant and completion, ready is high in the completion cycle and the line becomes Shared.
- R3: On a write miss, the controller issues command 10 and the line becomes Modified when the transaction completes.
- R4: A write to a Shared line issues an upgrade, command 11, and the line becomes Modified when the transaction completes.
- R5: Reads of Shared or Modified lines, and writes to Modified lines, raise pr_ready_o combinationally in the request cycle. They issue no bus request and leave the state unchanged.
- R6: A snooped read (01) that matches a Modified line raises flush_o in that cycle, with flush_addr_o equal to the snoop address. The line becomes Shared.
- R7: A snooped read-exclusive or upgrade (10 or 11) that matches a line makes it Invalid. flush_o is raised in that cycle only if the line was Modified.
- R8: A snooped read that matches a Shared line raises no flush and leaves the line Shared.
- R9: A snoop whose tag differs from the stored tag, or that targets an Invalid line, raises no flush and changes no state.
- R10: When a snoop and a local request reach the same line in the same cycle, the snoop is applied first, and the request is judged against the state after the snoop.
- R11: After a miss is accepted, pr_ready_o stays low until the completion cycle. bus_req_o and bus_addr_o hold until grant, and bus_req_o drops after grant.
- R12: Snoops are ignored from grant until completion, while the bus carries this controller's own transaction.
- R13: A pending upgrade whose line is invalidated by a snoop before grant is presented as command 10 from that same cycle onward.
- R14: A miss to an index that holds a Modified line with another tag raises flush_o with that line's address in the launch cycle and invalidates it. If a snoop flush occupies the cycle, the launch waits one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pr_valid_i | input | 1 | Processor request valid, held until ready |
| pr_write_i | input | 1 | Request is a write |
| pr_addr_i | input | ADDR_W | Request line address, held until ready |
| pr_ready_o | output | 1 | Request completed |
| bus_req_o | output | 1 | Bus request, held until grant |
| bus_cmd_o | output | 2 | Bus command code |
| bus_addr_o | output | ADDR_W | Bus transaction address |
| bus_gnt_i | input | 1 | Bus grant pulse |
| bus_done_i | input | 1 | Own transaction completed |
| snp_valid_i | input | 1 | Snooped command valid |
| snp_cmd_i | input | 2 | Snooped command code |
| snp_addr_i | input | ADDR_W | Snooped address |
| flush_o | output | 1 | Dirty data must be supplied or written back |
| flush_addr_o | output | ADDR_W | Address of flushed line |

## Verification
Hit responses and snoop flushes are combinational, so the bench samples ready and flush one nanosecond after it drives the request or snoop, in the same cycle. A miss shows bus_req_o one edge later, and a state change made by a snoop or a commit is only visible through a later request. The bench therefore confirms each new state with a follow-up access whose hit or miss behaviour depends on it. During grant and completion phases the bench checks ready and request in every waiting cycle, and it samples the completion cycle before the edge that consumes the handshake.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_M = 2'b10} line_st_e;
  typedef enum logic [1:0] {BC_NONE = 2'b00, BC_RD = 2'b01, BC_RDX = 2'b10, BC_UPG = 2'b11} bus_cmd_e;
  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_WAIT} fsm_e;
endpackage

// File: rtl/msi_line_tbl.sv
`timescale 1ns/1ps
module msi_line_tbl
  import msi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snp_en_i,
  input  bus_cmd_e         snp_cmd_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  output logic             snp_flush_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output line_st_e         rd_st_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  line_st_e         wr_st_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  localparam int NLINES = 1 << IDX_W;

  logic [NLINES-1:0][1:0]       st_eff;
  logic [NLINES-1:0][TAG_W-1:0] tag_v;
  logic [NLINES-1:0]            fl_v;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    line_st_e         st_q, st_snp;
    logic [TAG_W-1:0] tag_q;
    logic             hit;

    assign hit = snp_en_i && (snp_cmd_i != BC_NONE) && (snp_idx_i == IDX_W'(i))
                 && (tag_q == snp_tag_i) && (st_q != ST_I);

    // snooped read keeps a readable copy, exclusive kinds drop it
    always_comb begin
      st_snp = st_q;
      if (hit) st_snp = (snp_cmd_i == BC_RD) ? ST_S : ST_I;
    end

    assign fl_v[i]    = hit && (st_q == ST_M);
    assign st_eff[i]  = st_snp;
    assign tag_v[i]   = tag_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= ST_I;
        tag_q <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
        st_q  <= wr_st_i;
        tag_q <= wr_tag_i;
      end else begin
        st_q  <= st_snp;
      end
    end
  end

  assign rd_st_o     = line_st_e'(st_eff[rd_idx_i]);
  assign rd_tag_o    = tag_v[rd_idx_i];
  assign snp_flush_o = |fl_v;
endmodule

// File: rtl/msi_req_fsm.sv
`timescale 1ns/1ps
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pr_valid_i,
  input  logic              pr_write_i,
  input  logic [ADDR_W-1:0] pr_addr_i,
  output logic              pr_ready_o,
  input  line_st_e          line_st_i,
  input  logic [ADDR_W-IDX_W-1:0] line_tag_i,
  input  logic              snp_flush_i,
  input  logic              bus_gnt_i,
  input  logic              bus_done_i,
  output logic              bus_req_o,
  output bus_cmd_e          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              snp_en_o,
  output logic              wr_en_o,
  output line_st_e          wr_st_o,
  output logic [ADDR_W-IDX_W-1:0] wr_tag_o,
  output logic              vic_flush_o,
  output logic [ADDR_W-1:0] vic_addr_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_e              fs_q, fs_d;
  bus_cmd_e          cmd_q, cmd_d, miss_cmd, cur_cmd;
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  pr_tag;
  logic              tag_eq, hit, vic_dirty;
  line_st_e          eff_st;

  assign pr_tag    = pr_addr_i[ADDR_W-1:IDX_W];
  assign tag_eq    = (line_tag_i == pr_tag);
  assign eff_st    = tag_eq ? line_st_i : ST_I;
  assign hit       = pr_write_i ? (eff_st == ST_M) : (eff_st != ST_I);
  assign miss_cmd  = !pr_write_i ? BC_RD : ((eff_st == ST_S) ? BC_UPG : BC_RDX);
  assign vic_dirty = !tag_eq && (line_st_i == ST_M);
  // upgrade lost its copy before grant: fetch as well
  assign cur_cmd   = ((cmd_q == BC_UPG) && (eff_st != ST_S)) ? BC_RDX : cmd_q;
  assign vic_addr_o = {line_tag_i, pr_addr_i[IDX_W-1:0]};
  assign bus_addr_o = addr_q;

  always_comb begin
    fs_d        = fs_q;
    cmd_d       = cmd_q;
    pr_ready_o  = 1'b0;
    bus_req_o   = 1'b0;
    bus_cmd_o   = BC_NONE;
    snp_en_o    = 1'b1;
    wr_en_o     = 1'b0;
    wr_st_o     = ST_I;
    wr_tag_o    = line_tag_i;
    vic_flush_o = 1'b0;
    unique case (fs_q)
      FS_IDLE: begin
        if (pr_valid_i) begin
          if (hit) begin
            pr_ready_o = 1'b1;
          end else if (!(vic_dirty && snp_flush_i)) begin
            fs_d  = FS_REQ;
            cmd_d = miss_cmd;
            if (vic_dirty) begin
              vic_flush_o = 1'b1;
              wr_en_o     = 1'b1;
            end
          end
        end
      end
      FS_REQ: begin
        bus_req_o = 1'b1;
        bus_cmd_o = cur_cmd;
        cmd_d     = cur_cmd;
        if (bus_gnt_i) fs_d = FS_WAIT;
      end
      FS_WAIT: begin
        bus_cmd_o = cmd_q;
        snp_en_o  = 1'b0;
        if (bus_done_i) begin
          wr_en_o    = 1'b1;
          wr_st_o    = (cmd_q == BC_RD) ? ST_S : ST_M;
          wr_tag_o   = pr_tag;
          pr_ready_o = 1'b1;
          fs_d       = FS_IDLE;
        end
      end
      default: fs_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q   <= FS_IDLE;
      cmd_q  <= BC_NONE;
      addr_q <= '0;
    end else begin
      fs_q  <= fs_d;
      cmd_q <= cmd_d;
      if (fs_q == FS_IDLE && fs_d == FS_REQ) addr_q <= pr_addr_i;
    end
  end
endmodule

// File: rtl/msi_coh_ctrl.sv
`timescale 1ns/1ps
module msi_coh_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pr_valid_i,
  input  logic              pr_write_i,
  input  logic [ADDR_W-1:0] pr_addr_i,
  output logic              pr_ready_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              bus_done_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              flush_o,
  output logic [ADDR_W-1:0] flush_addr_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_st_e          line_st, wr_st;
  logic [TAG_W-1:0]  line_tag, wr_tag;
  logic              snp_flush, snp_en, wr_en, vic_flush;
  logic [ADDR_W-1:0] vic_addr;
  bus_cmd_e          bus_cmd;

  msi_line_tbl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .snp_en_i    (snp_valid_i && snp_en),
    .snp_cmd_i   (bus_cmd_e'(snp_cmd_i)),
    .snp_idx_i   (snp_addr_i[IDX_W-1:0]),
    .snp_tag_i   (snp_addr_i[ADDR_W-1:IDX_W]),
    .snp_flush_o (snp_flush),
    .rd_idx_i    (pr_addr_i[IDX_W-1:0]),
    .rd_st_o     (line_st),
    .rd_tag_o    (line_tag),
    .wr_en_i     (wr_en),
    .wr_idx_i    (pr_addr_i[IDX_W-1:0]),
    .wr_st_i     (wr_st),
    .wr_tag_i    (wr_tag)
  );

  msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pr_valid_i  (pr_valid_i),
    .pr_write_i  (pr_write_i),
    .pr_addr_i   (pr_addr_i),
    .pr_ready_o  (pr_ready_o),
    .line_st_i   (line_st),
    .line_tag_i  (line_tag),
    .snp_flush_i (snp_flush),
    .bus_gnt_i   (bus_gnt_i),
    .bus_done_i  (bus_done_i),
    .bus_req_o   (bus_req_o),
    .bus_cmd_o   (bus_cmd),
    .bus_addr_o  (bus_addr_o),
    .snp_en_o    (snp_en),
    .wr_en_o     (wr_en),
    .wr_st_o     (wr_st),
    .wr_tag_o    (wr_tag),
    .vic_flush_o (vic_flush),
    .vic_addr_o  (vic_addr)
  );

  assign bus_cmd_o    = bus_cmd;
  assign flush_o      = snp_flush || vic_flush;
  assign flush_addr_o = vic_flush ? vic_addr : snp_addr_i;
endmodule

// File: rtl/msi_coh_ctrl_chk.sv
`timescale 1ns/1ps
module msi_coh_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pr_valid_i,
  input logic              pr_ready_o,
  input logic              bus_req_o,
  input logic [1:0]        bus_cmd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_gnt_i,
  input logic              snp_valid_i,
  input logic              flush_o
);
  // R5
  hit_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_ready_o |-> !bus_req_o);
  // R11
  ready_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_ready_o |-> pr_valid_i);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o)));
  // R11
  req_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i) |=> !bus_req_o);
  // R13
  req_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_cmd_o != 2'b00));
  // R14
  flush_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (snp_valid_i || pr_valid_i));
endmodule

bind msi_coh_ctrl msi_coh_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pr_valid_i  (pr_valid_i),
  .pr_ready_o  (pr_ready_o),
  .bus_req_o   (bus_req_o),
  .bus_cmd_o   (bus_cmd_o),
  .bus_addr_o  (bus_addr_o),
  .bus_gnt_i   (bus_gnt_i),
  .snp_valid_i (snp_valid_i),
  .flush_o     (flush_o)
);

// File: tb/msi_coh_ctrl_bench.sv
`timescale 1ns/1ps
module msi_coh_ctrl_bench;
  localparam int AW = 16, IW = 3, TW = AW - IW, NL = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          pr_valid = 0, pr_write = 0, bus_gnt = 0, bus_done = 0, snp_valid = 0;
  logic [AW-1:0] pr_addr = '0, snp_addr = '0;
  logic [1:0]    snp_cmd = 2'b00;
  logic          pr_ready, bus_req, flush;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr, flush_addr;

  msi_coh_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u_msi_coh_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .pr_valid_i(pr_valid), .pr_write_i(pr_write), .pr_addr_i(pr_addr), .pr_ready_o(pr_ready),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_gnt_i(bus_gnt), .bus_done_i(bus_done),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .flush_o(flush), .flush_addr_o(flush_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [TW-1:0] m_tag [NL];
  logic [1:0]    m_st  [NL];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int t, input int i);
    return {TW'(t), IW'(i)};
  endfunction

  function automatic logic [1:0] eff(input logic [AW-1:0] a);
    return (m_tag[a[IW-1:0]] == a[AW-1:IW]) ? m_st[a[IW-1:0]] : 2'b00;
  endfunction

  function automatic logic [1:0] miss_cmd(input logic w, input logic [1:0] e);
    return !w ? 2'b01 : ((e == 2'b01) ? 2'b11 : 2'b10);
  endfunction

  task automatic commit(input logic w, input logic [AW-1:0] a);
    m_tag[a[IW-1:0]] = a[AW-1:IW];
    m_st[a[IW-1:0]]  = w ? 2'b10 : 2'b01;
  endtask

  // entered at negedge+1 in the first cycle after launch
  task automatic bus_phase(input logic [1:0] ecmd, input logic [AW-1:0] a, input string rq,
                           input int gd, input int dd);
    chk(rq, bus_req, 1); chk(rq, bus_cmd, ecmd); chk(rq, bus_addr, a);
    repeat (gd) begin
      @(negedge clk); #1;
      chk("R11", bus_req, 1); chk("R11", pr_ready, 0);
    end
    @(negedge clk); bus_gnt = 1; #1;
    chk("R11", bus_req, 1);
    @(negedge clk); bus_gnt = 0; #1;
    chk("R11", bus_req, 0); chk("R11", pr_ready, 0);
    repeat (dd) begin
      @(negedge clk); #1;
      chk("R11", pr_ready, 0);
    end
    @(negedge clk); bus_done = 1; #1;
    chk("R2", pr_ready, 1);
  endtask

  task automatic do_req(input logic w, input logic [AW-1:0] a, input string rq,
                        input int gd, input int dd);
    logic [1:0] e;
    logic       vic;
    @(negedge clk); pr_valid = 1; pr_write = w; pr_addr = a; #1;
    e = eff(a);
    if (w ? (e == 2'b10) : (e != 2'b00)) begin
      chk(rq, pr_ready, 1); chk(rq, bus_req, 0); chk(rq, flush, 0);
    end else begin
      chk(rq, pr_ready, 0);
      vic = (m_tag[a[IW-1:0]] != a[AW-1:IW]) && (m_st[a[IW-1:0]] == 2'b10);
      chk("R14", flush, vic);
      if (vic) begin
        chk("R14", flush_addr, {m_tag[a[IW-1:0]], a[IW-1:0]});
        m_st[a[IW-1:0]] = 2'b00;
      end
      @(negedge clk); #1;
      bus_phase(miss_cmd(w, e), a, rq, gd, dd);
      commit(w, a);
    end
    @(negedge clk); pr_valid = 0; bus_done = 0;
  endtask

  task automatic do_snoop(input logic [1:0] c, input logic [AW-1:0] a, input string rq);
    logic [IW-1:0] i;
    logic          hit, ef;
    i   = a[IW-1:0];
    hit = (m_tag[i] == a[AW-1:IW]) && (m_st[i] != 2'b00);
    ef  = hit && (m_st[i] == 2'b10);
    @(negedge clk); snp_valid = 1; snp_cmd = c; snp_addr = a; #1;
    chk(rq, flush, ef);
    if (ef) chk(rq, flush_addr, a);
    if (hit) m_st[i] = (c == 2'b01) ? 2'b01 : 2'b00;
    @(negedge clk); snp_valid = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [AW-1:0] A, B, A2, C;
    A = mk(1, 2); B = mk(1, 5); A2 = mk(2, 2); C = mk(3, 6);
    for (int i = 0; i < NL; i++) begin m_tag[i] = '0; m_st[i] = 2'b00; end
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    chk("R1", pr_ready, 0); chk("R1", bus_req, 0); chk("R1", flush, 0);
    rst_n = 1;

    do_req(0, A, "R1", 0, 0);       // I -> S via read
    do_req(0, A, "R5", 0, 0);
    do_req(1, B, "R3", 2, 1);       // I -> M via read-exclusive
    do_req(1, B, "R5", 0, 0);
    do_req(1, A, "R4", 1, 0);       // S -> M via upgrade
    do_req(0, A, "R5", 0, 0);

    do_snoop(2'b01, A, "R6");       // M -> S with flush
    do_req(1, A, "R6", 0, 0);       // upgrade proves S
    do_snoop(2'b01, A, "R6");
    do_snoop(2'b01, A, "R8");       // S stays S, no flush
    do_req(0, A, "R8", 0, 0);

    do_snoop(2'b10, A, "R7");       // S -> I, no flush
    do_req(0, A, "R7", 0, 0);       // read miss proves I
    do_snoop(2'b11, B, "R7");       // M -> I with flush
    do_snoop(2'b10, A2, "R9");      // tag mismatch
    do_req(0, A, "R9", 0, 0);
    do_snoop(2'b01, B, "R9");       // invalid line

    // R10: snoop read and local write to the same M line in one cycle
    do_req(1, A, "R10", 0, 0);
    @(negedge clk); pr_valid = 1; pr_write = 1; pr_addr = A;
    snp_valid = 1; snp_cmd = 2'b01; snp_addr = A; #1;
    chk("R10", flush, 1); chk("R10", pr_ready, 0);
    m_st[A[IW-1:0]] = 2'b01;
    @(negedge clk); snp_valid = 0; #1;
    bus_phase(2'b11, A, "R10", 0, 0);
    commit(1, A);
    @(negedge clk); pr_valid = 0; bus_done = 0;

    // R13: upgrade pending, line invalidated before grant
    do_snoop(2'b01, A, "R13");
    @(negedge clk); pr_valid = 1; pr_write = 1; pr_addr = A; #1;
    chk("R13", pr_ready, 0);
    @(negedge clk); snp_valid = 1; snp_cmd = 2'b10; snp_addr = A; #1;
    chk("R13", bus_req, 1); chk("R13", flush, 0); chk("R13", bus_cmd, 2'b10);
    m_st[A[IW-1:0]] = 2'b00;
    @(negedge clk); snp_valid = 0; #1;
    bus_phase(2'b10, A, "R13", 1, 0);
    commit(1, A);
    @(negedge clk); pr_valid = 0; bus_done = 0;

    // R12: snoop to a dirty line while own transaction owns the bus
    @(negedge clk); pr_valid = 1; pr_write = 0; pr_addr = C; #1;
    chk("R12", pr_ready, 0);
    @(negedge clk); bus_gnt = 1; #1;
    chk("R12", bus_req, 1);
    @(negedge clk); bus_gnt = 0; snp_valid = 1; snp_cmd = 2'b01; snp_addr = A; #1;
    chk("R12", flush, 0);
    @(negedge clk); snp_valid = 0; bus_done = 1; #1;
    chk("R12", pr_ready, 1);
    commit(0, C);
    @(negedge clk); pr_valid = 0; bus_done = 0;
    do_req(1, A, "R12", 0, 0);      // still M

    // R14: dirty victim write-back
    do_req(1, B, "R14", 0, 0);
    do_req(0, A2, "R14", 0, 0);
    do_req(1, A, "R14", 0, 0);
    @(negedge clk); pr_valid = 1; pr_write = 0; pr_addr = A2;
    snp_valid = 1; snp_cmd = 2'b01; snp_addr = B; #1;
    chk("R14", flush, 1); chk("R14", flush_addr, B);
    m_st[B[IW-1:0]] = 2'b01;
    @(negedge clk); snp_valid = 0; #1;
    chk("R14", flush, 1); chk("R14", flush_addr, A); chk("R14", bus_req, 0);
    m_st[A[IW-1:0]] = 2'b00;
    @(negedge clk); #1;
    bus_phase(2'b01, A2, "R14", 0, 0);
    commit(0, A2);
    @(negedge clk); pr_valid = 0; bus_done = 0;

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = mk($urandom_range(0, 3), $urandom_range(0, NL - 1));
      if ($urandom_range(0, 9) < 6)
        do_req(1'($urandom_range(0, 1)), a, "R5", $urandom_range(0, 3), $urandom_range(0, 2));
      else
        do_snoop(2'($urandom_range(1, 3)), a, "R7");
    end

    summary();
  end
endmodule